// File: doc/BRIEF.md
# Input Capture Timebase Pair

This block holds two 16-bit capture timebases, channel 0 (even) and channel 1 (odd). Each channel has a control word, a free-running counter and a capture register. Each channel picks one line out of a shared vector of event inputs through a 5-bit source index.

The selected line can act in one of two ways, chosen per channel:

- **Sync mode:** it restarts a running counter.
- **Trigger mode:** it releases a counter that a status flag holds at zero. Software may also set or clear that flag.

A rising edge on a channel's capture pin copies the count into that channel's capture register. When both channels set their cascade bit, the pair forms one 32-bit timebase. Channel 0 is the low half and governs the pair.

Events and capture pins are synchronous, active-high levels that are sampled at the rising clock edge. Reset is synchronous and active-high.

Top module: `ictm_pair`

## Requirements
- R1: After reset both control words read 0x000D and both capture registers read 0.
- R2: Control word layout: bit 8 is cascade, bit 7 is mode (1 = trigger, 0 = sync), bit 6 is trigger status, and bits 4:0 are the source index into `ev_in`. Bits 15:9 and bit 5 always read 0, so writing 0xFFFF reads back as 0x01DF.
- R3: While neither cleared nor held, a counter advances by one each clock and wraps from 0xFFFF to 0x0000.
- R4: In trigger mode with status 0, the counter stays at 0. A selected event sets status at the next edge while the count stays 0 at that edge. The count reaches 1 one edge later. Further events while status is 1 change nothing.
- R5: In sync mode, a selected event makes the count 0 at the next edge, and counting continues afterwards. Status neither holds the counter nor is set by events.
- R6: Sources flagged in parameter `TRIG_ONLY_MASK` (by default indices 28 to 31) are ignored in sync mode.
- R7: In trigger mode, writing status 0 holds the count at 0 from the following edge. Writing status 1 starts counting with no event. A control write wins over a hardware status set in the same cycle.
- R8: A capture pin that is high at an edge after being low at the previous edge latches the count present before that edge. A pin that stays high latches nothing more.
- R9: Cascade is active only when bit 8 is set in both channels. Channel 0's mode, status and source then clear or hold both halves. The high half advances only at an edge where the low half wraps. A rising edge on `cap_in[0]` latches low into `cap_val[0]` and high into `cap_val[1]`.
- R10: A capture edge that coincides with a sync clear latches the count from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 2 | Per-channel control write enable |
| ctl_wdata | input | 16 | Control write data shared by both channels |
| ctl_rdata | output | 2x16 | Control word readback per channel |
| ev_in | input | 32 | Event lines selectable as sync or trigger sources |
| cap_in | input | 2 | Capture pins, one per channel |
| cap_val | output | 2xCNT_W | Capture registers, one per channel |

## Verification
Two functions can fall in the same edge: a capture and a sync clear. The bench drives the selected event and the capture pin high across one common edge. It then expects the capture register to show the count from before the clear, while the counter restarts from zero.

A second pairing also falls in one cycle: a control write that clears status and a trigger event. The bench judges it through the status bit in the readback and through a later capture of zero.

// File: rtl/ictm_pkg.sv
package ictm_pkg;
  localparam int CTL_W = 16;
  localparam int SEL_W = 5;
  localparam int SRC_N = 1 << SEL_W;
  localparam logic [CTL_W-1:0] CTL_RESET = 16'h000D;

  typedef struct packed {
    logic             casc;
    logic             trig;
    logic             tstat;
    logic [SEL_W-1:0] sel;
  } ictm_ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(input ictm_ctl_t c);
    return {7'b0, c.casc, c.trig, c.tstat, 1'b0, c.sel};
  endfunction

  function automatic ictm_ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
    ictm_ctl_t c;
    c.casc  = w[8];
    c.trig  = w[7];
    c.tstat = w[6];
    c.sel   = w[SEL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/ictm_ctl.sv
module ictm_ctl import ictm_pkg::*; #(
  parameter logic [SRC_N-1:0] TRIG_ONLY_MASK = 32'hF000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic [SRC_N-1:0] ev_in,
  output ictm_ctl_t        ctl_q,
  output logic             sync_hit,
  output logic             hold
);
  logic evt;
  logic hw_set;

  assign evt      = ev_in[ctl_q.sel];
  assign hold     = ctl_q.trig && !ctl_q.tstat;
  assign hw_set   = hold && evt;
  assign sync_hit = !ctl_q.trig && evt && !TRIG_ONLY_MASK[ctl_q.sel];

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= ctl_unpack(CTL_RESET);
    else if (we)     ctl_q <= ctl_unpack(wdata);
    else if (hw_set) ctl_q.tstat <= 1'b1;
  end
endmodule

// File: rtl/ictm_counter.sv
module ictm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                               input logic c, input logic i);
    if (c)      return '0;
    else if (i) return cur + 1'b1;
    else        return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= next_count(cnt, clr, inc);
  end
endmodule

// File: rtl/ictm_capture.sv
module ictm_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin,
  input  logic         take,
  input  logic [W-1:0] cnt,
  output logic         rise,
  output logic [W-1:0] cap
);
  logic pin_q;

  assign rise = pin && !pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      cap   <= '0;
    end else begin
      pin_q <= pin;
      if (take) cap <= cnt;
    end
  end
endmodule

// File: rtl/ictm_pair.sv
module ictm_pair import ictm_pkg::*; #(
  parameter int               CNT_W          = 16,
  parameter logic [SRC_N-1:0] TRIG_ONLY_MASK = 32'hF000_0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  ctl_we,
  input  logic [CTL_W-1:0]            ctl_wdata,
  output logic [1:0][CTL_W-1:0]       ctl_rdata,
  input  logic [SRC_N-1:0]            ev_in,
  input  logic [1:0]                  cap_in,
  output logic [1:0][CNT_W-1:0]       cap_val
);
  localparam int NCH = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ictm_ctl_t [NCH-1:0]            ctl_q;
  logic [NCH-1:0]                 sync_hit, hold, clr, inc, cap_rise, take;
  logic [NCH-1:0][CNT_W-1:0]      cnt;
  logic                           casc_on;
  logic                           low_wrap;

  function automatic logic wraps(input logic [CNT_W-1:0] c, input logic cl, input logic in);
    return !cl && in && (c == CNT_MAX);
  endfunction

  assign casc_on  = ctl_q[0].casc && ctl_q[1].casc;
  assign low_wrap = wraps(cnt[0], clr[0], inc[0]);

  always_comb begin
    clr[0]  = sync_hit[0] || hold[0];
    inc[0]  = 1'b1;
    take[0] = cap_rise[0];
    if (casc_on) begin
      clr[1]  = clr[0];
      inc[1]  = low_wrap;
      take[1] = cap_rise[0];
    end else begin
      clr[1]  = sync_hit[1] || hold[1];
      inc[1]  = 1'b1;
      take[1] = cap_rise[1];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ictm_ctl #(.TRIG_ONLY_MASK(TRIG_ONLY_MASK)) u_ctl (
      .clk(clk), .rst(rst), .we(ctl_we[g]), .wdata(ctl_wdata), .ev_in(ev_in),
      .ctl_q(ctl_q[g]), .sync_hit(sync_hit[g]), .hold(hold[g])
    );
    ictm_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr[g]), .inc(inc[g]), .cnt(cnt[g])
    );
    ictm_capture #(.W(CNT_W)) u_cap (
      .clk(clk), .rst(rst), .pin(cap_in[g]), .take(take[g]), .cnt(cnt[g]),
      .rise(cap_rise[g]), .cap(cap_val[g])
    );
    assign ctl_rdata[g] = ctl_pack(ctl_q[g]);
  end
endmodule

// File: rtl/ictm_pair_chk.sv
module ictm_pair_chk import ictm_pkg::*; #(
  parameter int W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            ctl_we,
  input logic [SRC_N-1:0]      ev_in,
  input logic [SEL_W-1:0]      sel0,
  input logic                  tstat0,
  input logic [1:0]            hold,
  input logic [1:0]            sync_hit,
  input logic [1:0]            clr,
  input logic [1:0]            cap_rise,
  input logic                  casc_on,
  input logic [1:0][W-1:0]     cnt,
  input logic [1:0][W-1:0]     cap_val
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr[0]) |=> (cnt[0] == W'($past(cnt[0]) + 1'b1)));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    hold[0] |=> (cnt[0] == '0));

  p_trig_sets_status_r4: assert property (@(posedge clk) disable iff (rst)
    (hold[0] && ev_in[sel0] && !ctl_we[0]) |=> tstat0);

  p_sync_clear_r5: assert property (@(posedge clk) disable iff (rst)
    sync_hit[0] |=> (cnt[0] == '0));

  p_capture_r8: assert property (@(posedge clk) disable iff (rst)
    cap_rise[0] |=> (cap_val[0] == $past(cnt[0])));

  p_high_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (casc_on && !clr[0] && cnt[0] == TOP) |=> (cnt[1] == W'($past(cnt[1]) + 1'b1)));

  p_high_still_r9: assert property (@(posedge clk) disable iff (rst)
    (casc_on && !clr[0] && cnt[0] != TOP) |=> $stable(cnt[1]));
endmodule

bind ictm_pair ictm_pair_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ev_in(ev_in),
  .sel0(ctl_q[0].sel), .tstat0(ctl_q[0].tstat),
  .hold(hold), .sync_hit(sync_hit), .clr(clr), .cap_rise(cap_rise),
  .casc_on(casc_on), .cnt(cnt), .cap_val(cap_val)
);

// File: tb/ictm_pair_bench.sv
module ictm_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       ctl_we = '0;
  logic [15:0]      ctl_wdata = '0;
  logic [1:0][15:0] ctl_rdata;
  logic [31:0]      ev_in = '0;
  logic [1:0]       cap_in = '0;
  logic [1:0][15:0] cap_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ictm_pair u_ictm_pair (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ev_in(ev_in), .cap_in(cap_in), .cap_val(cap_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [15:0] v);
    ctl_we[ch] = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we[ch] = 1'b0;
  endtask

  task automatic pulse_ev(input int src);
    ev_in[src] = 1'b1;
    @(negedge clk);
    ev_in[src] = 1'b0;
  endtask

  // latches at the first edge; the count advances by two over the task
  task automatic cap(input int ch);
    cap_in[ch] = 1'b1;
    @(negedge clk);
    cap_in[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ctl0", ctl_rdata[0], 16'h000D);
    check("R1 ctl1", ctl_rdata[1], 16'h000D);
    check("R1 cap", cap_val, 32'h0);
  endtask

  task automatic t_readback;
    wr(1, 16'hFFFF);
    check("R2 unimplemented bits", ctl_rdata[1], 16'h01DF);
    wr(1, 16'h000D);
  endtask

  task automatic t_sync;
    wr(0, 16'h0003);
    pulse_ev(3);
    idle(10);
    cap(0);
    check("R5 sync restart", cap_val[0], 16'd10);
    check("R5 status untouched", ctl_rdata[0], 16'h0003);
    idle(5);
    ev_in[3] = 1'b1; cap_in[0] = 1'b1;
    @(negedge clk);
    ev_in[3] = 1'b0; cap_in[0] = 1'b0;
    @(negedge clk);
    check("R10 pre-clear capture", cap_val[0], 16'd17);
    idle(3);
    cap(0);
    check("R10 restart after clear", cap_val[0], 16'd4);
  endtask

  task automatic t_trig_only;
    wr(0, 16'h0003);
    pulse_ev(3);
    wr(0, 16'h001E);
    idle(4);
    pulse_ev(30);
    idle(2);
    cap(0);
    check("R6 trigger-only source ignored in sync", cap_val[0], 16'd8);
  endtask

  task automatic t_trigger;
    wr(0, 16'h0085);
    idle(3);
    cap(0);
    check("R4 held while waiting", cap_val[0], 16'd0);
    check("R4 status clear", ctl_rdata[0], 16'h0085);
    pulse_ev(5);
    check("R4 status set", ctl_rdata[0], 16'h00C5);
    idle(6);
    cap(0);
    check("R4 count after trigger", cap_val[0], 16'd6);
    pulse_ev(5);
    idle(1);
    cap(0);
    check("R4 repeat event no effect", cap_val[0], 16'd10);
  endtask

  task automatic t_soft_status;
    wr(0, 16'h0085);
    idle(2);
    cap(0);
    check("R7 cleared status holds", cap_val[0], 16'd0);
    wr(0, 16'h00C5);
    idle(4);
    cap(0);
    check("R7 written status runs", cap_val[0], 16'd4);
    wr(0, 16'h0085);
    ctl_we[0] = 1'b1; ctl_wdata = 16'h0085; ev_in[5] = 1'b1;
    @(negedge clk);
    ctl_we[0] = 1'b0; ev_in[5] = 1'b0;
    check("R7 write wins over event", ctl_rdata[0], 16'h0085);
    idle(2);
    cap(0);
    check("R7 still held", cap_val[0], 16'd0);
  endtask

  task automatic t_hold_high;
    wr(1, 16'h0007);
    pulse_ev(7);
    idle(9);
    cap(1);
    check("R8 ch1 capture", cap_val[1], 16'd9);
    cap_in[1] = 1'b1;
    idle(5);
    check("R8 level does not recapture", cap_val[1], 16'd11);
    cap_in[1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_cascade;
    wr(0, 16'h0103);
    pulse_ev(7);
    idle(3);
    cap(1);
    check("R9 one-sided cascade stays split", cap_val[1], 16'd3);
    wr(1, 16'h0107);
    pulse_ev(3);
    idle(65535);
    cap(0);
    check("R9 low half at top", cap_val[0], 16'hFFFF);
    check("R9 high half before wrap", cap_val[1], 16'h0000);
    idle(1);
    cap(0);
    check("R3 low half wrapped", cap_val[0], 16'd2);
    check("R9 high half stepped", cap_val[1], 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_sync();
    t_trig_only();
    t_trigger();
    t_soft_status();
    t_hold_high();
    t_cascade();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule